// File: doc/BRIEF.md
# Interrupt Source Lifecycle Tracker

This block keeps the handling state of a parameterised number of interrupt sources. Each source is inactive, pending, active, or active with a further pending request waiting behind the one in service. A source is configured for edge or level triggering. It can also be flagged as a message-style source, which has no active state at all. Hardware lines, a software set-pending strobe, acknowledge strobes and deactivate strobes move each source through its lifecycle. Each strobe carries a source ID.

The block reports per-source pending and active bits and a vector of sources that may be offered to a processor. A source can be offered only when it is pending, not active, and enabled. Priority selection, routing and register decoding sit outside the block. The three valid/ID strobe pairs stand in for software register writes.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every source is inactive: `pend_o`, `act_o` and `present_o` are all zero.
- R2: In edge mode (`level_mode_i[i]`=0), a rising edge on `irq_i[i]` makes the source pending one clock later. It stays pending whatever the line does until the source is acknowledged. Edges are detected against a registered copy of the line.
- R3: In level mode (`level_mode_i[i]`=1), the line's contribution to pending follows `irq_i[i]` with one clock of latency and disappears when the line drops.
- R4: An acknowledge (`ack_valid_i`, `ack_id_i`=i) of a source that is pending and not active makes it active on the next clock. It clears any latched (edge or software) pending request. A level source whose line is still high becomes active-and-pending.
- R5: While a source is active, a new edge or software set makes it active-and-pending. Such a source is not offered on `present_o`.
- R6: A deactivate (`deact_valid_i`, `deact_id_i`=i) of an active source clears its active bit on the next clock and leaves its pending bit unchanged. Active-and-pending becomes pending, and active becomes inactive.
- R7: A source with `msg_type_i[i]`=1 never becomes active. An acknowledge of it returns it directly to inactive.
- R8: A software set (`set_valid_i`, `set_id_i`=i) makes the source pending one clock later, independent of its line and trigger mode.
- R9: `present_o[i]` equals `pend_o[i]` and not `act_o[i]` and `enable_i[i]`.
- R10: Strobes that do not apply are ignored and change no output. This covers an acknowledge of a source that is not pending or is already active, a deactivate of a source that is not active, and any strobe whose ID is N_SRC or above.
- R11: A software set and an acknowledge of the same pending source in the same cycle leave it active-and-pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_SRC | Raw interrupt lines, active high |
| level_mode_i | input | N_SRC | 1 = level triggered, 0 = edge triggered |
| msg_type_i | input | N_SRC | 1 = message-style source with no active state |
| enable_i | input | N_SRC | Per-source presentation enable |
| set_valid_i | input | 1 | Software set-pending strobe |
| set_id_i | input | ID_W | Target of the set strobe |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | Target of the acknowledge |
| deact_valid_i | input | 1 | Deactivate strobe |
| deact_id_i | input | ID_W | Target of the deactivate |
| pend_o | output | N_SRC | Pending bit per source |
| act_o | output | N_SRC | Active bit per source |
| present_o | output | N_SRC | Sources eligible to be offered |

## Verification
The hardest state to reach is active-and-pending, with a deactivate arriving afterwards. The source must first be pended and acknowledged. Then a fresh request must be made while it is in service, by a second edge, a held level line, or a software set. The bench builds this explicitly for edge, level and software paths, then deactivates and acknowledges again. It also times a set and an acknowledge into the same cycle. A seeded random phase then mixes lines and strobes, including out-of-range IDs, against the per-clock reference model.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PEND     = 2'b01,
    ST_ACT      = 2'b10,
    ST_ACT_PEND = 2'b11
  } src_state_e;

  function automatic src_state_e to_state(input logic pend, input logic act);
    return src_state_e'({act, pend});
  endfunction
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode #(
  parameter int N_SRC = 6,
  parameter int ID_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ID_W-1:0]  id_i,
  output logic [N_SRC-1:0] hit_o
);
  always_comb begin
    hit_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (valid_i && (32'(id_i) == i)) hit_o[i] = 1'b1;
  end

  // R10: an ID that names no source selects nothing
  a_r10_one_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
  a_r10_no_hit_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (hit_o == '0));
endmodule

// File: rtl/line_sampler.sv
module line_sampler #(
  parameter int N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  output logic [N_SRC-1:0] irq_q_o,
  output logic [N_SRC-1:0] rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q_o <= '0;
    else         irq_q_o <= irq_i;

  assign rise_o = irq_i & ~irq_q_o;

  a_r2_rise_from_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rise_o |=> ((irq_q_o & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/src_state_cell.sv
module src_state_cell
  import irq_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       line_q_i,
  input  logic       level_mode_i,
  input  logic       msg_i,
  input  logic       set_i,
  input  logic       ack_i,
  input  logic       deact_i,
  output src_state_e state_o
);
  logic latch_q, act_q, pend;
  logic ack_ok, deact_ok, edge_ev;

  assign pend     = latch_q | (level_mode_i & line_q_i);
  assign ack_ok   = ack_i & pend & ~act_q;
  assign deact_ok = deact_i & act_q;
  assign edge_ev  = rise_i & ~level_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      latch_q <= (latch_q & ~ack_ok) | edge_ev | set_i;
      act_q   <= (act_q & ~deact_ok) | (ack_ok & ~msg_i);
    end
  end

  assign state_o = to_state(pend, act_q);

  a_r2_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !ack_ok) |=> latch_q);
  a_r4_ack_activates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pend && !act_q && !msg_i) |=> act_q);
  a_r6_active_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !deact_i) |=> act_q);
  a_r7_msg_no_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> !$past(msg_i));
  a_r8_set_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> latch_q);
  a_r10_ack_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && act_q && !deact_i) |=> act_q);
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irq_state_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int ID_W  = (N_SRC > 1) ? $clog2(N_SRC + 1) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] level_mode_i,
  input  logic [N_SRC-1:0] msg_type_i,
  input  logic [N_SRC-1:0] enable_i,
  input  logic             set_valid_i,
  input  logic [ID_W-1:0]  set_id_i,
  input  logic             ack_valid_i,
  input  logic [ID_W-1:0]  ack_id_i,
  input  logic             deact_valid_i,
  input  logic [ID_W-1:0]  deact_id_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] act_o,
  output logic [N_SRC-1:0] present_o
);
  logic [N_SRC-1:0] set_hit, ack_hit, deact_hit, line_q, rise;

  strobe_decode #(.N_SRC(N_SRC), .ID_W(ID_W)) u_dec_set (
    .clk_i, .rst_ni, .valid_i(set_valid_i), .id_i(set_id_i), .hit_o(set_hit));
  strobe_decode #(.N_SRC(N_SRC), .ID_W(ID_W)) u_dec_ack (
    .clk_i, .rst_ni, .valid_i(ack_valid_i), .id_i(ack_id_i), .hit_o(ack_hit));
  strobe_decode #(.N_SRC(N_SRC), .ID_W(ID_W)) u_dec_deact (
    .clk_i, .rst_ni, .valid_i(deact_valid_i), .id_i(deact_id_i), .hit_o(deact_hit));

  line_sampler #(.N_SRC(N_SRC)) u_lines (
    .clk_i, .rst_ni, .irq_i, .irq_q_o(line_q), .rise_o(rise));

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    src_state_e st;
    src_state_cell u_cell (
      .clk_i, .rst_ni,
      .rise_i(rise[g]), .line_q_i(line_q[g]),
      .level_mode_i(level_mode_i[g]), .msg_i(msg_type_i[g]),
      .set_i(set_hit[g]), .ack_i(ack_hit[g]), .deact_i(deact_hit[g]),
      .state_o(st));
    assign pend_o[g]    = st[0];
    assign act_o[g]     = st[1];
    assign present_o[g] = (st == ST_PEND) & enable_i[g];

    a_r9_present_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      present_o[g] |-> (enable_i[g] && pend_o[g] && !act_o[g]));
    a_r6_deact_keeps_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (deact_hit[g] && act_o[g] && st == ST_ACT_PEND && !ack_hit[g]
       && level_mode_i[g] == 1'b0) |=> pend_o[g] && !act_o[g]);
  end
endmodule

// File: tb/tb_irq_state_tracker.sv
module tb_irq_state_tracker;
  localparam int N  = 6;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq = '0, lvl = 6'b001100, msg = 6'b100000, en = '1;
  logic set_v = 0, ack_v = 0, dea_v = 0;
  logic [IW-1:0] set_id = '0, ack_id = '0, dea_id = '0;
  logic [N-1:0] pend, act, pres;

  always #2 clk = ~clk;

  irq_state_tracker #(.N_SRC(N), .ID_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .level_mode_i(lvl),
    .msg_type_i(msg), .enable_i(en),
    .set_valid_i(set_v), .set_id_i(set_id),
    .ack_valid_i(ack_v), .ack_id_i(ack_id),
    .deact_valid_i(dea_v), .deact_id_i(dea_id),
    .pend_o(pend), .act_o(act), .present_o(pres));

  // reference model
  bit m_held[N], m_act[N], m_line[N];
  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  function automatic bit m_pend(int i);
    return m_held[i] || (lvl[i] && m_line[i]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_held[i] = 0; m_act[i] = 0; m_line[i] = 0; end
    end else begin
      bit nh[N], na[N];
      for (int i = 0; i < N; i++) begin
        bit ack_ok, set_h, edge_h, dea_ok;
        ack_ok = ack_v && (int'(ack_id) == i) && m_pend(i) && !m_act[i];
        set_h  = set_v && (int'(set_id) == i);
        edge_h = !lvl[i] && irq[i] && !m_line[i];
        dea_ok = dea_v && (int'(dea_id) == i) && m_act[i];
        nh[i] = (m_held[i] && !ack_ok) || edge_h || set_h;
        na[i] = (m_act[i] && !dea_ok) || (ack_ok && !msg[i]);
      end
      for (int i = 0; i < N; i++) begin
        m_held[i] = nh[i]; m_act[i] = na[i]; m_line[i] = irq[i];
      end
    end
  end

  task automatic compare();
    logic [N-1:0] ep, ea, epr;
    for (int i = 0; i < N; i++) begin
      ep[i] = m_pend(i); ea[i] = m_act[i]; epr[i] = ep[i] && !ea[i] && en[i];
    end
    compared++;
    if (pend !== ep) begin mismatched++;
      $display("FAIL %s pend act=%b exp=%b t=%0t", cur_req, pend, ep, $time); end
    compared++;
    if (act !== ea) begin mismatched++;
      $display("FAIL %s active act=%b exp=%b t=%0t", cur_req, act, ea, $time); end
    compared++;
    if (pres !== epr) begin mismatched++;
      $display("FAIL %s present act=%b exp=%b t=%0t", cur_req, pres, epr, $time); end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      set_v = 0; ack_v = 0; dea_v = 0;
      compare();
    end
  endtask

  task automatic do_set(int id);   set_v = 1; set_id = IW'(id); tick(); endtask
  task automatic do_ack(int id);   ack_v = 1; ack_id = IW'(id); tick(); endtask
  task automatic do_deact(int id); dea_v = 1; dea_id = IW'(id); tick(); endtask

  task automatic expect_src(int i, bit p, bit a, string tag);
    compared++;
    if (pend[i] !== p || act[i] !== a) begin
      mismatched++;
      $display("FAIL %s src%0d pend/act act=%b%b exp=%b%b", tag, i, pend[i], act[i], p, a);
    end
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1;
    compared++;
    if (pend !== '0 || act !== '0 || pres !== '0) begin mismatched++;
      $display("FAIL R1 reset outputs act=%b%b%b exp=0", pend, act, pres); end
    #9 rst_n = 1;
    tick(2);

    // R2 edge latch
    cur_req = "R2";
    irq[0] = 1; tick(); expect_src(0, 1, 0, "R2");
    irq[0] = 0; tick(3); expect_src(0, 1, 0, "R2");
    // R4 / R6
    cur_req = "R4"; do_ack(0); expect_src(0, 0, 1, "R4");
    cur_req = "R6"; do_deact(0); expect_src(0, 0, 0, "R6");
    // R5 active-and-pending via second edge
    cur_req = "R5";
    irq[0] = 1; tick(); irq[0] = 0; tick(); do_ack(0);
    irq[0] = 1; tick(); irq[0] = 0; tick();
    expect_src(0, 1, 1, "R5");
    compared++; if (pres[0] !== 1'b0) begin mismatched++;
      $display("FAIL R5 present act=%b exp=0", pres[0]); end
    cur_req = "R6"; do_deact(0); expect_src(0, 1, 0, "R6");
    do_ack(0); do_deact(0); expect_src(0, 0, 0, "R6");
    // R3 level
    cur_req = "R3";
    irq[2] = 1; tick(); expect_src(2, 1, 0, "R3");
    irq[2] = 0; tick(); expect_src(2, 0, 0, "R3");
    irq[2] = 1; tick(2);
    cur_req = "R4"; do_ack(2); expect_src(2, 1, 1, "R4");
    irq[2] = 0; tick(); expect_src(2, 0, 1, "R3");
    cur_req = "R6"; do_deact(2); expect_src(2, 0, 0, "R6");
    // R7 message-style
    cur_req = "R7";
    do_set(5); do_ack(5); expect_src(5, 0, 0, "R7");
    irq[5] = 1; tick(); irq[5] = 0; do_ack(5); expect_src(5, 0, 0, "R7");
    // R8 software set on level source with low line
    cur_req = "R8";
    do_set(3); tick(2); expect_src(3, 1, 0, "R8");
    do_ack(3); do_set(3); expect_src(3, 1, 1, "R5");
    do_deact(3); do_ack(3); do_deact(3); expect_src(3, 0, 0, "R8");
    // R9 enable gating
    cur_req = "R9";
    en[4] = 0; do_set(4); tick();
    compared++; if (pres[4] !== 1'b0) begin mismatched++;
      $display("FAIL R9 present act=%b exp=0", pres[4]); end
    en[4] = 1; tick();
    compared++; if (pres[4] !== 1'b1) begin mismatched++;
      $display("FAIL R9 present act=%b exp=1", pres[4]); end
    // R10 ignored strobes
    cur_req = "R10";
    do_ack(1); expect_src(1, 0, 0, "R10");
    do_deact(1); expect_src(1, 0, 0, "R10");
    do_ack(7); do_deact(6); do_set(7); expect_src(4, 1, 0, "R10");
    do_ack(4); do_set(4); do_ack(4); expect_src(4, 1, 1, "R10");
    do_deact(4); do_ack(4); do_deact(4);
    // R11 set and ack together
    cur_req = "R11";
    do_set(1);
    set_v = 1; set_id = 1; ack_v = 1; ack_id = 1; tick();
    expect_src(1, 1, 1, "R11");
    do_deact(1); do_ack(1); do_deact(1);

    // mixed random phase
    cur_req = "R2";
    for (int c = 0; c < 2000; c++) begin
      irq   = N'($urandom);
      set_v = ($urandom % 4) == 0; set_id = IW'($urandom);
      ack_v = ($urandom % 3) == 0; ack_id = IW'($urandom);
      dea_v = ($urandom % 3) == 0; dea_id = IW'($urandom);
      if (c % 97 == 0) en = N'($urandom);
      cur_req = (c % 2) ? "R10" : "R5";
      @(posedge clk); #1;
      set_v = 0; ack_v = 0; dea_v = 0;
      compare();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule